// File: doc/BRIEF.md
# Masked Interrupt Source Controller

This block gathers interrupt events from five functional units of a supply and interface chip: a high-side driver group, a LIN transceiver, a voltage monitor that reports supply overvoltage, a thermal prewarning detector and a supply undervoltage detector. Three of them pass through a write-only enable mask. The last two always get through. An accepted event sets a pending flag. While any flag is set, the block pulls its active-low interrupt line low.

A host reads a 4-bit source code to find out which unit raised the interrupt. That read also acknowledges the reported source. When several sources are pending, they are reported one at a time in a fixed priority order. After each acknowledge that leaves work behind, the interrupt line is released for ten ticks of a 1 µs timebase and is then pulled low again. Every write to the mask returns the current source code as response data, and that write acknowledges nothing.

Top module: `irq_source_ctrl`

## Requirements
- R1: After power-on reset the three mask enables read as enabled, with the encoding 1 = enabled and 0 = disabled. A mask write takes its enables from the write data: bit 0 is the overvoltage enable, bit 1 is the LIN enable and bit 2 is the high-side enable. Bit 3 is ignored.
- R2: An event from a disabled source sets no pending flag and does not drive irq_n low. The event is dropped, so enabling the source later raises nothing.
- R3: Undervoltage and thermal prewarning events always set their pending flag, whatever the mask holds.
- R4: irq_n is high after reset and whenever no flag is pending. irq_n is low whenever a flag is pending and no release window is running.
- R5: The source code is 0 when nothing is pending.
- R6: A read strobe returns the current source code on rdata in the next cycle and clears the reported flag. If no other flag remains, irq_n goes high and stays high.
- R7: If flags remain after an acknowledge, irq_n stays high for exactly 10 us_tick pulses and goes low on the cycle after the tenth pulse.
- R8: A mask write strobe returns the current source code on rdata in the next cycle and clears no flag.
- R9: Pending sources are reported in priority order, highest first. The codes are undervoltage = 1, thermal prewarning = 2, overvoltage = 3, LIN = 4 and high side = 5.
- R10: A read during a release window acknowledges the next source, returns its code, and restarts the 10-tick window if flags still remain.
- R11: An event that arrives on the same cycle as the acknowledge of its own source leaves that source pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| ev_hs | input | 1 | High-side driver event |
| ev_lin | input | 1 | LIN transceiver event |
| ev_ovp | input | 1 | Supply overvoltage event (maskable) |
| ev_tpw | input | 1 | Thermal prewarning event (unmaskable) |
| ev_uv | input | 1 | Supply undervoltage event (unmaskable) |
| wr_mask | input | 1 | Mask write strobe |
| rd_src | input | 1 | Source read and acknowledge strobe |
| wdata | input | 4 | Mask write data |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| rdata | output | 4 | Response data: source code captured at the last strobe |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench fires all five sources together and reads them out one after another. A wrong priority encoder would show the codes in the wrong order, and an acknowledge that cleared too much would end the sequence early. The bench counts release ticks up to nine and then to ten, which exposes an off-by-one counter, and it reads inside a release window to catch a timer that fails to restart. It also checks that events from masked sources do not come back once the mask is lifted, and that an event arriving on the same cycle as its own acknowledge stays pending. Either fault would show up there as a wrong code or a wrong irq_n level.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;
  localparam int NSRC   = 5;
  localparam int CODE_W = 4;
  localparam int MASK_W = 3;
  // Index order is the service priority: lowest index served first.
  localparam int IDX_UV  = 0;
  localparam int IDX_TPW = 1;
  localparam int IDX_OVP = 2;
  localparam int IDX_LIN = 3;
  localparam int IDX_HS  = 4;

  // One-hot of the lowest set bit (the highest-priority pending source).
  function automatic logic [NSRC-1:0] first_set(input logic [NSRC-1:0] v);
    logic [NSRC-1:0] r;
    logic            found;
    r     = '0;
    found = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (v[i] && !found) begin
        r[i]  = 1'b1;
        found = 1'b1;
      end
    end
    return r;
  endfunction

  // Source code of a one-hot grant: index plus one, zero when empty.
  function automatic logic [CODE_W-1:0] code_of(input logic [NSRC-1:0] g);
    logic [CODE_W-1:0] c;
    c = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (g[i]) c = CODE_W'(i + 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_src_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CODE_W-1:0] wdata,
  output logic [MASK_W-1:0] mask_q
);
  logic unused_wbits;
  assign unused_wbits = ^wdata[CODE_W-1:MASK_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mask_q <= '1;
    else if (wr) mask_q <= wdata[MASK_W-1:0];
  end

  a_r1_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> mask_q == $past(wdata[MASK_W-1:0]));
  a_r1_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(mask_q));
endmodule

// File: rtl/irq_pending.sv
module irq_pending
  import irq_src_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] ev,
  input  logic [NSRC-1:0] en,
  input  logic [NSRC-1:0] ack_vec,
  output logic [NSRC-1:0] pend_q,
  output logic            more_after
);
  logic [NSRC-1:0] set_vec;
  logic [NSRC-1:0] pend_d;

  assign set_vec    = ev & en;
  assign pend_d     = (pend_q & ~ack_vec) | set_vec;
  assign more_after = |pend_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    a_r2_masked_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_q[i] && !en[i]) |=> !pend_q[i]);
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_vec[i] && !set_vec[i]) |=> !pend_q[i]);
    a_r11_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> pend_q[i]);
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_src_pkg::*;
(
  input  logic [NSRC-1:0]   pend,
  output logic [NSRC-1:0]   grant,
  output logic [CODE_W-1:0] code
);
  always_comb begin
    grant = first_set(pend);
    code  = code_of(grant);
    a_r9_grant_onehot: assert ($onehot0(grant));
    a_r5_idle_code_zero: assert ((|pend) || (code == '0));
  end
endmodule

// File: rtl/irq_release_timer.sv
module irq_release_timer #(
  parameter int REL_TICKS = 10,
  parameter int CNT_W     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  input  logic tick,
  output logic releasing
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(REL_TICKS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      releasing <= 1'b0;
      cnt       <= '0;
    end else if (start) begin
      releasing <= 1'b1;
      cnt       <= LOAD;
    end else if (stop) begin
      releasing <= 1'b0;
      cnt       <= '0;
    end else if (releasing && tick) begin
      if (cnt == LAST) begin
        releasing <= 1'b0;
        cnt       <= '0;
      end else begin
        cnt <= cnt - LAST;
      end
    end
  end

  a_r7_window_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (releasing && !tick && !stop) |=> releasing);
  a_r7_no_spurious_window: assert property (@(posedge clk) disable iff (!rst_n)
    (!releasing && !start) |=> !releasing);
endmodule

// File: rtl/irq_source_ctrl.sv
module irq_source_ctrl
  import irq_src_pkg::*;
#(
  parameter int REL_TICKS = 10,
  parameter int CNT_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_hs,
  input  logic              ev_lin,
  input  logic              ev_ovp,
  input  logic              ev_tpw,
  input  logic              ev_uv,
  input  logic              wr_mask,
  input  logic              rd_src,
  input  logic [CODE_W-1:0] wdata,
  input  logic              us_tick,
  output logic [CODE_W-1:0] rdata,
  output logic              irq_n
);
  logic [MASK_W-1:0] mask_q;
  logic [NSRC-1:0]   ev_vec, en_vec, pend, grant, ack_vec;
  logic [CODE_W-1:0] code;
  logic              more_after, rel_start, rel_stop, releasing;

  assign ev_vec[IDX_UV]  = ev_uv;
  assign ev_vec[IDX_TPW] = ev_tpw;
  assign ev_vec[IDX_OVP] = ev_ovp;
  assign ev_vec[IDX_LIN] = ev_lin;
  assign ev_vec[IDX_HS]  = ev_hs;

  assign en_vec[IDX_UV]  = 1'b1;
  assign en_vec[IDX_TPW] = 1'b1;
  assign en_vec[IDX_OVP] = mask_q[0];
  assign en_vec[IDX_LIN] = mask_q[1];
  assign en_vec[IDX_HS]  = mask_q[2];

  irq_mask_reg u_mask (
    .clk(clk), .rst_n(rst_n), .wr(wr_mask), .wdata(wdata), .mask_q(mask_q));

  irq_pending u_pend (
    .clk(clk), .rst_n(rst_n), .ev(ev_vec), .en(en_vec), .ack_vec(ack_vec),
    .pend_q(pend), .more_after(more_after));

  irq_arbiter u_arb (.pend(pend), .grant(grant), .code(code));

  assign ack_vec   = rd_src ? grant : '0;
  assign rel_start = rd_src && (|pend) && more_after;
  assign rel_stop  = rd_src && !more_after;

  irq_release_timer #(.REL_TICKS(REL_TICKS), .CNT_W(CNT_W)) u_rel (
    .clk(clk), .rst_n(rst_n), .start(rel_start), .stop(rel_stop),
    .tick(us_tick), .releasing(releasing));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 rdata <= '0;
    else if (rd_src || wr_mask) rdata <= code;
  end

  assign irq_n = !(|pend) || releasing;

  a_r8_write_returns_code: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && !rd_src) |=> rdata == $past(code));
  a_r8_write_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && !rd_src) |=> ((pend & $past(pend)) == $past(pend)));
  a_r6_read_returns_code: assert property (@(posedge clk) disable iff (!rst_n)
    rd_src |=> rdata == $past(code));
endmodule

// File: tb/tb_irq_source_ctrl.sv
module tb_irq_source_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_hs = 0, ev_lin = 0, ev_ovp = 0, ev_tpw = 0, ev_uv = 0;
  logic       wr_mask = 0, rd_src = 0, us_tick = 0;
  logic [3:0] wdata = '0;
  logic [3:0] rdata;
  logic       irq_n;

  int n_checks = 0;
  int n_fail   = 0;

  irq_source_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ev_hs(ev_hs), .ev_lin(ev_lin), .ev_ovp(ev_ovp),
    .ev_tpw(ev_tpw), .ev_uv(ev_uv), .wr_mask(wr_mask), .rd_src(rd_src),
    .wdata(wdata), .us_tick(us_tick), .rdata(rdata), .irq_n(irq_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Event bits: {hs, lin, ovp, tpw, uv}
  task automatic fire(input logic [4:0] e);
    {ev_hs, ev_lin, ev_ovp, ev_tpw, ev_uv} = e;
    cyc();
    {ev_hs, ev_lin, ev_ovp, ev_tpw, ev_uv} = '0;
  endtask

  task automatic read_src(output int c);
    rd_src = 1'b1;
    cyc();
    rd_src = 1'b0;
    c = int'(rdata);
  endtask

  task automatic write_mask(input logic [3:0] m, output int c);
    wr_mask = 1'b1;
    wdata   = m;
    cyc();
    wr_mask = 1'b0;
    c = int'(rdata);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      us_tick = 1'b1;
      cyc();
      us_tick = 1'b0;
      cyc();
    end
  endtask

  task automatic t_reset();
    int c;
    check("R4 reset irq_n", irq_n, 1);
    check("R5 reset rdata", rdata, 0);
    fire(5'b10000);
    check("R1 hs enabled after reset", irq_n, 0);
    read_src(c);
    check("R1 hs code", c, 5);
    check("R6 irq_n high after last ack", irq_n, 1);
    ticks(12);
    check("R6 irq_n stays high", irq_n, 1);
  endtask

  task automatic t_masked();
    int c;
    write_mask(4'b1000, c);
    check("R8 idle write returns 0", c, 0);
    fire(5'b11100);
    check("R2 masked sources no irq", irq_n, 1);
    write_mask(4'b0111, c);
    check("R2 dropped events stay dropped", irq_n, 1);
    read_src(c);
    check("R5 nothing pending code 0", c, 0);
    write_mask(4'b0010, c);   // LIN only
    fire(5'b00100);
    check("R1 overvoltage disabled by bit 0", irq_n, 1);
    fire(5'b01000);
    check("R1 lin enabled by bit 1", irq_n, 0);
    read_src(c);
    check("R1 lin code", c, 4);
  endtask

  task automatic t_unmaskable();
    int c;
    write_mask(4'b0000, c);
    fire(5'b00001);
    check("R3 undervoltage unmaskable", irq_n, 0);
    read_src(c);
    check("R3 undervoltage code", c, 1);
    check("R6 released after ack", irq_n, 1);
    fire(5'b00010);
    check("R3 prewarning unmaskable", irq_n, 0);
    read_src(c);
    check("R3 prewarning code", c, 2);
    write_mask(4'b0111, c);
  endtask

  task automatic t_priority();
    int c;
    fire(5'b11111);
    check("R4 pending drives irq low", irq_n, 0);
    read_src(c);
    check("R9 first code undervoltage", c, 1);
    check("R7 release starts", irq_n, 1);
    ticks(9);
    check("R7 still released after 9 ticks", irq_n, 1);
    ticks(1);
    check("R7 low after 10 ticks", irq_n, 0);
    read_src(c);
    check("R9 second code prewarning", c, 2);
    ticks(3);
    read_src(c);
    check("R10 read in window gives next", c, 3);
    check("R10 still released", irq_n, 1);
    ticks(9);
    check("R10 window restarted", irq_n, 1);
    ticks(1);
    check("R10 low after restarted window", irq_n, 0);
    read_src(c);
    check("R9 fourth code lin", c, 4);
    ticks(10);
    read_src(c);
    check("R9 fifth code high side", c, 5);
    ticks(12);
    check("R6 idle after all acked", irq_n, 1);
    read_src(c);
    check("R5 empty code", c, 0);
  endtask

  task automatic t_write_returns();
    int c;
    fire(5'b01000);
    write_mask(4'b0111, c);
    check("R8 write returns lin code", c, 4);
    check("R8 write does not ack", irq_n, 0);
    read_src(c);
    check("R8 still pending after write", c, 4);
  endtask

  task automatic t_same_cycle();
    int c;
    fire(5'b01000);
    rd_src = 1'b1;
    ev_lin = 1'b1;
    cyc();
    rd_src = 1'b0;
    ev_lin = 1'b0;
    check("R11 ack returned lin", rdata, 4);
    ticks(10);
    check("R11 lin re-raised", irq_n, 0);
    read_src(c);
    check("R11 lin still pending", c, 4);
    check("R6 idle after final ack", irq_n, 1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_masked();
    t_unmaskable();
    t_priority();
    t_write_returns();
    t_same_cycle();
    summary();
    $finish;
  end
endmodule